// File: doc/BRIEF.md
# Symbol-Driven FEC Block Segmenter

This block sits between the symbol buffer of a downlink receiver and the forward-error-correction decoder. It takes demodulated data one OFDMA symbol at a time, not one complete burst at a time, so no full-frame memory is required. Each incoming word carries the identifier of the burst it belongs to. The block cuts each burst's words into FEC blocks whose size comes from a small per-burst descriptor table. It writes each word directly into a fixed slot of an external block buffer.

A burst that has a partly filled block keeps its slot across symbol boundaries, so one FEC block may span several symbols. Completed blocks are announced in the order they complete, whatever their burst. Each announcement carries the slot, the burst id, a per-burst block index and the block length, so bursts can be rebuilt downstream. A new symbol is requested from the upstream queue only when the block is idle and enough slots are free. The downstream side returns a slot by pulsing a release with the slot index.

Top module: `fec_seg`

## Requirements
- R1: After reset, `fetch`, `buf_we`, `done_valid` and `err` are 0, all slots are free, and every descriptor is invalid.
- R2: `fetch` pulses for one cycle only when no symbol is in progress, `sym_rdy` is high and at least `SYM_SLOTS` slots are free, sampled at the edge before the pulse. After a pulse, no further `fetch` occurs until the word flagged `in_eos` has been accepted.
- R3: Each accepted word is written one cycle later: `buf_we`=1, `buf_slot` is the burst's slot and `buf_off` is the word's 0-based position inside its block.
- R4: When a burst's block fill reaches its descriptor block size, `done_valid` pulses in the same cycle as the final write. It reports `done_short`=0 and `done_len` equal to the block size, and the slot is no longer bound to the burst.
- R5: The end-of-symbol marker does not close a partial block. The next word of that burst, in a later symbol, continues in the same slot at the next offset.
- R6: When a burst's accepted word count reaches its descriptor length, any open block closes with `done_short`=1 if `done_len` is below the block size, and `done_len` is the actual word count of that block.
- R7: Each burst fills its own slot independently, so blocks of different bursts complete and are reported interleaved, in completion order.
- R8: `done_idx` counts 0, 1, 2, … per burst, and `frame_start` resets every burst's index, word count and partial block.
- R9: A word whose burst has no valid descriptor, or whose burst has already reached its length, is dropped with no write and no completion, and it sets `err`. `err` stays set until an accepted `frame_start`.
- R10: A new block takes the lowest-numbered free slot. A slot stays occupied after completion until `rel_valid` pulses with its index.
- R11: Descriptor writes (`cfg_we`, valid when `cfg_blk` is 1..`BLKMAX`) and `frame_start` take effect only while no symbol is in progress, and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_bid | input | BW | Burst id being configured |
| cfg_blk | input | FW | Block size in words (1..BLKMAX valid, other values invalidate) |
| cfg_len | input | LW | Total burst length in words |
| frame_start | input | 1 | Frame start pulse |
| sym_rdy | input | 1 | Upstream symbol queue is not empty |
| fetch | output | 1 | Pop one symbol from the upstream queue |
| in_valid | input | 1 | Data word valid |
| in_bid | input | BW | Burst id of the word |
| in_data | input | DW | Data word |
| in_eos | input | 1 | Last word of the current symbol |
| buf_we | output | 1 | Block buffer write enable |
| buf_slot | output | SW | Block buffer slot |
| buf_off | output | AW | Word offset inside the slot |
| buf_data | output | DW | Word written |
| done_valid | output | 1 | A block is complete (ready for the decoder) |
| done_slot | output | SW | Slot of the completed block |
| done_bid | output | BW | Burst id of the completed block |
| done_idx | output | IW | Per-burst block index |
| done_len | output | FW | Block length in words |
| done_short | output | 1 | Block closed early by the burst-length limit |
| rel_valid | input | 1 | Downstream releases a slot |
| rel_slot | input | SW | Slot released |
| err | output | 1 | Sticky dropped-word flag |

## Verification
The bench interleaves three bursts with different block sizes across four symbols. One partial block straddles a symbol end, which a design that closed blocks at `in_eos` would report as short. It also drives bursts up to their length limit, where a design that ignored the limit would keep writing, or would report a short block as full. Directed tests fill the slots until only one is free to confirm that `fetch` is held back, and then check that the released slot is the one reused. Further directed tests send words to an unconfigured burst and to an exhausted burst, and issue a descriptor write and a `frame_start` in the middle of a symbol. A design that ignored the busy gating would then accept words it should drop.

// File: rtl/fec_seg.sv
module fec_seg #(
  parameter int DW        = 16,
  parameter int NB        = 8,
  parameter int NS        = 8,
  parameter int BLKMAX    = 64,
  parameter int LW        = 12,
  parameter int IW        = 8,
  parameter int SYM_SLOTS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(NB)-1:0]        cfg_bid,
  input  logic [$clog2(BLKMAX+1)-1:0]  cfg_blk,
  input  logic [LW-1:0]                cfg_len,
  input  logic                         frame_start,
  input  logic                         sym_rdy,
  output logic                         fetch,
  input  logic                         in_valid,
  input  logic [$clog2(NB)-1:0]        in_bid,
  input  logic [DW-1:0]                in_data,
  input  logic                         in_eos,
  output logic                         buf_we,
  output logic [$clog2(NS)-1:0]        buf_slot,
  output logic [$clog2(BLKMAX)-1:0]    buf_off,
  output logic [DW-1:0]                buf_data,
  output logic                         done_valid,
  output logic [$clog2(NS)-1:0]        done_slot,
  output logic [$clog2(NB)-1:0]        done_bid,
  output logic [IW-1:0]                done_idx,
  output logic [$clog2(BLKMAX+1)-1:0]  done_len,
  output logic                         done_short,
  input  logic                         rel_valid,
  input  logic [$clog2(NS)-1:0]        rel_slot,
  output logic                         err
);
  localparam int BW = $clog2(NB);
  localparam int SW = $clog2(NS);
  localparam int AW = $clog2(BLKMAX);
  localparam int FW = $clog2(BLKMAX+1);
  localparam int CW = $clog2(NS+1);

  logic          vld   [NB];
  logic [FW-1:0] blk   [NB];
  logic [LW-1:0] len   [NB];
  logic          open  [NB];
  logic [SW-1:0] oslot [NB];
  logic [FW-1:0] fill  [NB];
  logic [LW-1:0] cnt   [NB];
  logic [IW-1:0] idx   [NB];
  logic [NS-1:0] used;
  logic          busy;

  logic [CW-1:0] free_cnt;
  logic [SW-1:0] low_free;
  logic          has_free;

  always_comb begin
    free_cnt = '0;
    low_free = '0;
    has_free = 1'b0;
    for (int i = NS-1; i >= 0; i--) begin
      if (!used[i]) begin
        free_cnt = free_cnt + CW'(1);
        low_free = SW'(i);
        has_free = 1'b1;
      end
    end
  end

  wire           acc       = busy && in_valid;
  wire           ok        = vld[in_bid] && (cnt[in_bid] != len[in_bid]);
  wire [FW-1:0]  nfill     = FW'(fill[in_bid] + 1'b1);
  wire [LW-1:0]  ncnt      = LW'(cnt[in_bid] + 1'b1);
  wire           close     = (nfill == blk[in_bid]) || (ncnt == len[in_bid]);
  wire [SW-1:0]  cur       = open[in_bid] ? oslot[in_bid] : low_free;
  wire           new_alloc = acc && ok && !open[in_bid];
  wire           frame_go  = frame_start && !busy;
  wire           can_fetch = !busy && !frame_start && sym_rdy && (free_cnt >= CW'(SYM_SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        vld[b] <= 1'b0; blk[b] <= '0; len[b] <= '0;
        open[b] <= 1'b0; oslot[b] <= '0; fill[b] <= '0; cnt[b] <= '0; idx[b] <= '0;
      end
      used <= '0; busy <= 1'b0; fetch <= 1'b0; err <= 1'b0;
      buf_we <= 1'b0; buf_slot <= '0; buf_off <= '0; buf_data <= '0;
      done_valid <= 1'b0; done_slot <= '0; done_bid <= '0; done_idx <= '0;
      done_len <= '0; done_short <= 1'b0;
    end else begin
      fetch      <= 1'b0;
      buf_we     <= 1'b0;
      done_valid <= 1'b0;
      if (rel_valid) used[rel_slot] <= 1'b0;
      if (!busy && cfg_we) begin
        vld[cfg_bid] <= (cfg_blk != '0) && (cfg_blk <= FW'(BLKMAX));
        blk[cfg_bid] <= cfg_blk;
        len[cfg_bid] <= cfg_len;
      end
      if (frame_go) begin
        for (int b = 0; b < NB; b++) begin
          if (open[b]) used[oslot[b]] <= 1'b0;
          open[b] <= 1'b0; fill[b] <= '0; cnt[b] <= '0; idx[b] <= '0;
        end
        err <= 1'b0;
      end
      if (can_fetch) begin
        fetch <= 1'b1;
        busy  <= 1'b1;
      end
      if (acc) begin
        if (in_eos) busy <= 1'b0;
        if (ok) begin
          buf_we       <= 1'b1;
          buf_slot     <= cur;
          buf_off      <= fill[in_bid][AW-1:0];
          buf_data     <= in_data;
          used[cur]    <= 1'b1;
          cnt[in_bid]  <= ncnt;
          if (close) begin
            done_valid   <= 1'b1;
            done_slot    <= cur;
            done_bid     <= in_bid;
            done_idx     <= idx[in_bid];
            done_len     <= nfill;
            done_short   <= nfill != blk[in_bid];
            idx[in_bid]  <= idx[in_bid] + 1'b1;
            open[in_bid] <= 1'b0;
            fill[in_bid] <= '0;
          end else begin
            open[in_bid]  <= 1'b1;
            oslot[in_bid] <= cur;
            fill[in_bid]  <= nfill;
          end
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  // R2
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch) |-> $past(free_cnt) >= CW'(SYM_SLOTS));
  // R2
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> !fetch);
  // R3
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(in_valid));
  // R4
  full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_short) |-> done_len == blk[done_bid]);
  // R6
  short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_len != '0) && (done_len <= blk[done_bid]));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_alloc |-> has_free);
  // R10
  done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> used[done_slot]);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !frame_go) |=> err);
  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !buf_we);
endmodule

// File: tb/sim_fec_seg.sv
module sim_fec_seg;
  localparam int PERIOD = 10;
  localparam int NB = 8, NS = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, frame_start = 0, sym_rdy = 0, in_valid = 0, in_eos = 0, rel_valid = 0;
  logic [2:0] cfg_bid = 0, in_bid = 0, rel_slot = 0;
  logic [6:0] cfg_blk = 0;
  logic [11:0] cfg_len = 0;
  logic [15:0] in_data = 0;
  logic fetch, buf_we, done_valid, done_short, err;
  logic [2:0] buf_slot, done_slot, done_bid;
  logic [5:0] buf_off;
  logic [15:0] buf_data;
  logic [7:0] done_idx;
  logic [6:0] done_len;

  always #(PERIOD/2) clk = ~clk;

  fec_seg u0 (.clk, .rst_n, .cfg_we, .cfg_bid, .cfg_blk, .cfg_len, .frame_start,
    .sym_rdy, .fetch, .in_valid, .in_bid, .in_data, .in_eos, .buf_we, .buf_slot,
    .buf_off, .buf_data, .done_valid, .done_slot, .done_bid, .done_idx, .done_len,
    .done_short, .rel_valid, .rel_slot, .err);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  int m_blk[NB], m_len[NB], m_slot[NB], m_fill[NB], m_cnt[NB], m_idx[NB];
  bit m_vld[NB], m_open[NB], m_used[NS], m_err;

  // {eos, bid[2:0], data[15:0]}; b0 blk3 len7, b1 blk4 len6, b2 blk2 len4
  localparam logic [19:0] TBL [17] = '{
    20'h0A001, 20'h1A002, 20'h0A003, 20'h2A004, 20'h1A005, 20'h8A006,
    20'h1A007, 20'h2A008, 20'h1A009, 20'h0A00A, 20'hAA00B,
    20'h0A00C, 20'h1A00D, 20'h2A00E, 20'h0A00F, 20'h9A010,
    20'h8A011};

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int b, input int bs, input int ln);
    cfg_we = 1; cfg_bid = 3'(b); cfg_blk = 7'(bs); cfg_len = 12'(ln);
    @(negedge clk);
    cfg_we = 0;
    m_vld[b] = (bs >= 1 && bs <= 64); m_blk[b] = bs; m_len[b] = ln;
  endtask

  task automatic frame();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    for (int b = 0; b < NB; b++) begin
      if (m_open[b]) m_used[m_slot[b]] = 0;
      m_open[b] = 0; m_fill[b] = 0; m_cnt[b] = 0; m_idx[b] = 0;
    end
    m_err = 0;
  endtask

  function automatic int free_cnt();
    int n = 0;
    for (int s = 0; s < NS; s++) if (!m_used[s]) n++;
    return n;
  endfunction

  task automatic get_sym();
    sym_rdy = 1;
    @(negedge clk);
    chk("R2 fetch granted", fetch, 1);
    sym_rdy = 0;
  endtask

  task automatic rel(input int s);
    rel_valid = 1; rel_slot = 3'(s);
    @(negedge clk);
    rel_valid = 0;
    m_used[s] = 0;
  endtask

  task automatic rel_done();
    for (int s = 0; s < NS; s++) begin
      bit owned = 0;
      for (int b = 0; b < NB; b++) if (m_open[b] && m_slot[b] == s) owned = 1;
      if (m_used[s] && !owned) rel(s);
    end
  endtask

  task automatic send(input int b, input int d, input bit eos);
    bit ok, cl;
    int sl = 0, off = 0, nf, nc, ix = 0;
    ok = m_vld[b] && (m_cnt[b] < m_len[b]);
    cl = 0; nf = 0;
    if (ok) begin
      if (m_open[b]) sl = m_slot[b];
      else for (int s = NS-1; s >= 0; s--) if (!m_used[s]) sl = s;
      off = m_fill[b]; nf = m_fill[b] + 1; nc = m_cnt[b] + 1;
      cl = (nf == m_blk[b]) || (nc == m_len[b]);
      ix = m_idx[b];
      m_used[sl] = 1; m_cnt[b] = nc;
      if (cl) begin m_open[b] = 0; m_fill[b] = 0; m_idx[b]++; end
      else begin m_open[b] = 1; m_slot[b] = sl; m_fill[b] = nf; end
    end else m_err = 1;
    in_valid = 1; in_bid = 3'(b); in_data = 16'(d); in_eos = eos;
    @(negedge clk);
    in_valid = 0; in_eos = 0;
    if (ok) begin
      chk("R3 write enable", buf_we, 1);
      chk("R10 slot", buf_slot, sl);
      chk("R5 offset", buf_off, off);
      chk("R3 data", buf_data, d);
      chk("R7 completion", done_valid, cl);
      if (cl) begin
        chk("R7 burst id", done_bid, b);
        chk("R4 slot", done_slot, sl);
        chk("R8 index", done_idx, ix);
        chk("R6 length", done_len, nf);
        chk("R6 short flag", done_short, nf != m_blk[b]);
      end
    end else begin
      chk("R9 dropped write", buf_we, 0);
      chk("R9 dropped done", done_valid, 0);
    end
    chk("R9 err", err, m_err);
  endtask

  initial begin
    #(PERIOD*100000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_vld[b] = 0; m_open[b] = 0; m_fill[b] = 0; m_cnt[b] = 0; m_idx[b] = 0;
      m_blk[b] = 0; m_len[b] = 0; m_slot[b] = 0;
    end
    for (int s = 0; s < NS; s++) m_used[s] = 0;
    m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fetch", fetch, 0);
    chk("R1 buf_we", buf_we, 0);
    chk("R1 done", done_valid, 0);
    chk("R1 err", err, 0);

    cfg(0, 3, 7); cfg(1, 4, 6); cfg(2, 2, 4);
    frame();

    for (int i = 0; i < 17; i++) begin
      if (i == 0 || TBL[i-1][19]) get_sym();
      send(int'(TBL[i][18:16]), int'(TBL[i][15:0]), TBL[i][19]);
      if (TBL[i][19]) rel_done();
    end

    // R8, R9: new frame, index restarts, unconfigured and exhausted bursts
    frame();
    get_sym();
    send(2, 16'hB001, 0);
    send(2, 16'hB002, 0);
    send(7, 16'hB003, 0);
    send(2, 16'hB004, 0);
    send(2, 16'hB005, 0);
    send(2, 16'hB006, 1);
    rel_done();

    // R11: descriptor write and frame start while busy are ignored
    get_sym();
    cfg_we = 1; cfg_bid = 3'd5; cfg_blk = 7'd2; cfg_len = 12'd2;
    @(negedge clk);
    cfg_we = 0;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    send(2, 16'hC001, 0);
    send(5, 16'hC002, 1);

    // R2, R10: fetch held back with one free slot, released slot reused
    frame();
    chk("R9 err cleared", err, 0);
    cfg(3, 1, 20);
    get_sym();
    for (int k = 0; k < 7; k++) send(3, 16'hD000 + k, k == 6);
    chk("R10 free model", free_cnt(), 1);
    sym_rdy = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 fetch held", fetch, 0);
    end
    rel(3);
    chk("R2 fetch after release edge", fetch, 0);
    @(negedge clk);
    chk("R2 fetch granted", fetch, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 one fetch per symbol", fetch, 0);
    end
    sym_rdy = 0;
    send(3, 16'hD100, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule